// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Port

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a two-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port: it is written with control words and reads back as zero. The block does not count. It hands each channel a one-cycle load strobe with a 16-bit start value, and it drives the channel's mode code and BCD flag. It takes back each channel's live count and OUT level, so the host can read them.

Each channel holds four small state machines:
- The write sequencer has states `SEQ_LO` and `SEQ_HI`. In word mode a low-byte write moves it `SEQ_LO`→`SEQ_HI`. A high-byte write loads the count and moves it `SEQ_HI`→`SEQ_LO`. Programming a channel forces `SEQ_LO`.
- The live-read sequencer uses the same two states and the same transitions, driven by data-port reads in word mode.
- The count latch has states `CL_EMPTY`, `CL_BYTE_LO`, `CL_BYTE_HI`, `CL_WORD_LO` and `CL_WORD_HI`. A latch command moves it from `CL_EMPTY` into `CL_BYTE_LO`, `CL_BYTE_HI` or `CL_WORD_LO`, chosen by the access mode. A read moves `CL_BYTE_LO` or `CL_BYTE_HI` to `CL_EMPTY`, and moves `CL_WORD_LO`→`CL_WORD_HI`→`CL_EMPTY`.
- The status latch is either empty or held. A status request fills an empty latch. A read empties a held latch.

One bus operation is accepted per cycle; a write wins over a simultaneous read. Read data is registered, so it appears one cycle after the read strobe.

Top module: `tmr_host_port`

## Requirements
- R1: A control word with bits 7:6 = channel 0..2 and access field bits 5:4 ≠ 0 sets that channel's access mode, mode code (bits 3:1) and BCD flag (bit 0), all visible on the channel's outputs after the write's clock edge. It also returns both of that channel's byte sequencers to the low byte.
- R2: An access field of 0 latches the selected channel's count and leaves its mode code, BCD flag and access mode unchanged.
- R3: With access mode 1 (low byte only), a data write pulses the channel's load strobe for one cycle with value {8'h00, data}.
- R4: With access mode 2 (high byte only), a data write loads {data, 8'h00}.
- R5: With access mode 3 (word), the first data write is held and the second loads {second, first}. Only the second write pulses the strobe.
- R6: With no latch held, a data read returns the live count. Mode 1 gives the low byte, mode 2 gives the high byte, and mode 3 alternates low then high.
- R7: A count latch captures the live count on its command cycle. Reads return the captured value even if the live count changes afterwards.
- R8: A held count latch or held status latch is not replaced by a later latch or read-back command.
- R9: In word mode a latched count is released after its low and high bytes have been read. In byte modes it is released after one read. Later reads return the live count, and the live-read sequencer is left where it was.
- R10: A control word with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches count and bit 4 = 0 latches status on every selected channel. Unselected channels are unaffected.
- R11: The status byte is {OUT, 0, access[1:0], mode[2:0], BCD}.
- R12: A held status is returned by the next data read and is then cleared. A held count is returned after it.
- R13: A read of address 3 returns 0.
- R14: After reset each channel has access mode 3, mode 0, BCD 0, both sequencers at the low byte, both latches empty, no load strobe, and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe for one byte |
| addr | input | 2 | 0–2 channel data port, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | 16-bit load value per channel (channel c at bits 16c+15:16c) |
| chan_mode | output | 9 | 3-bit mode code per channel |
| chan_bcd | output | 3 | BCD flag per channel |
| live_cnt | input | 48 | Live 16-bit count per channel |
| out_lvl | input | 3 | OUT level per channel |

## Verification
Read data is due in the cycle after the clock edge that captures `rd_en`. The load strobe and the mode and BCD outputs change at the edge that captures the write, so they are observed in that same cycle. The bench drives just after a rising edge and samples at the falling edge. A monitor compares `rdata` only in the half-cycle that follows a captured read, and compares each load strobe in the half-cycle that follows the capturing edge, so every result is taken at the one point where it is due.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

    localparam int NUM_CH = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;

    typedef enum logic [2:0] {
        CL_EMPTY   = 3'd0,
        CL_BYTE_LO = 3'd1,
        CL_BYTE_HI = 3'd2,
        CL_WORD_LO = 3'd3,
        CL_WORD_HI = 3'd4
    } clat_e;

    typedef struct packed {
        logic              prog;
        logic              latch_cnt;
        logic              latch_sts;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cmd_t;

endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
    import tmr_host_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_ctl,
    input  logic [BYTE_W-1:0]            wdata,
    output chan_cmd_t [NUM_CH-1:0]       cmd
);

    logic is_readback;
    logic [NUM_CH-1:0] prog_vec;
    logic [NUM_CH-1:0] lat_vec;

    assign is_readback = (wdata[7:6] == 2'b11);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            cmd[c]           = '0;
            cmd[c].acc       = acc_e'(wdata[5:4]);
            cmd[c].mode      = wdata[3:1];
            cmd[c].bcd       = wdata[0];
            if (wr_ctl) begin
                if (is_readback) begin
                    if (wdata[c+1]) begin
                        cmd[c].latch_cnt = !wdata[5];
                        cmd[c].latch_sts = !wdata[4];
                    end
                end else if (wdata[7:6] == c[1:0]) begin
                    if (wdata[5:4] == 2'b00) begin
                        cmd[c].latch_cnt = 1'b1;
                    end else begin
                        cmd[c].prog = 1'b1;
                    end
                end
            end
        end
        assign prog_vec[c] = cmd[c].prog;
        assign lat_vec[c]  = cmd[c].latch_cnt;
    end

    // Programming reaches at most one channel per control word (R1)
    assert_one_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_vec));

    // A read-back never reprograms any channel (R10)
    assert_rb_no_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && is_readback) |-> (prog_vec == '0));

    // A plain counter-latch command touches a single channel (R2)
    assert_single_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !is_readback) |-> $onehot0(lat_vec));

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cmd_t         cmd,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);

    // state registers
    acc_e              acc_q, acc_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic              bcd_q, bcd_d;
    seq_e              wseq_q, wseq_d;
    seq_e              rseq_q, rseq_d;
    logic [BYTE_W-1:0] wlo_q, wlo_d;
    clat_e             clat_q, clat_d;
    logic [CNT_W-1:0]  cval_q, cval_d;
    logic              sts_vld_q, sts_vld_d;
    logic [BYTE_W-1:0] sts_q, sts_d;
    logic              ld_q, ld_d;
    logic [CNT_W-1:0]  ldv_q, ldv_d;

    // next-state process
    always_comb begin
        acc_d     = acc_q;
        mode_d    = mode_q;
        bcd_d     = bcd_q;
        wseq_d    = wseq_q;
        rseq_d    = rseq_q;
        wlo_d     = wlo_q;
        clat_d    = clat_q;
        cval_d    = cval_q;
        sts_vld_d = sts_vld_q;
        sts_d     = sts_q;
        ld_d      = 1'b0;
        ldv_d     = ldv_q;

        if (cmd.prog) begin
            acc_d  = cmd.acc;
            mode_d = cmd.mode;
            bcd_d  = cmd.bcd;
            wseq_d = SEQ_LO;
            rseq_d = SEQ_LO;
        end

        if (cmd.latch_cnt && clat_q == CL_EMPTY) begin
            cval_d = live_cnt;
            unique case (acc_q)
                ACC_HI:   clat_d = CL_BYTE_HI;
                ACC_WORD: clat_d = CL_WORD_LO;
                default:  clat_d = CL_BYTE_LO;
            endcase
        end

        if (cmd.latch_sts && !sts_vld_q) begin
            sts_d     = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
            sts_vld_d = 1'b1;
        end

        if (wr_hit) begin
            unique case (acc_q)
                ACC_HI: begin
                    ld_d  = 1'b1;
                    ldv_d = {wdata, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    unique case (wseq_q)
                        SEQ_LO: begin
                            wlo_d  = wdata;
                            wseq_d = SEQ_HI;
                        end
                        SEQ_HI: begin
                            ld_d   = 1'b1;
                            ldv_d  = {wdata, wlo_q};
                            wseq_d = SEQ_LO;
                        end
                        default: wseq_d = SEQ_LO;
                    endcase
                end
                default: begin
                    ld_d  = 1'b1;
                    ldv_d = {{BYTE_W{1'b0}}, wdata};
                end
            endcase
        end

        if (rd_hit) begin
            if (sts_vld_q) begin
                sts_vld_d = 1'b0;
            end else begin
                unique case (clat_q)
                    CL_BYTE_LO: clat_d = CL_EMPTY;
                    CL_BYTE_HI: clat_d = CL_EMPTY;
                    CL_WORD_LO: clat_d = CL_WORD_HI;
                    CL_WORD_HI: clat_d = CL_EMPTY;
                    default: begin
                        if (acc_q == ACC_WORD) begin
                            rseq_d = (rseq_q == SEQ_LO) ? SEQ_HI : SEQ_LO;
                        end
                    end
                endcase
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= ACC_WORD;
            mode_q    <= '0;
            bcd_q     <= 1'b0;
            wseq_q    <= SEQ_LO;
            rseq_q    <= SEQ_LO;
            wlo_q     <= '0;
            clat_q    <= CL_EMPTY;
            cval_q    <= '0;
            sts_vld_q <= 1'b0;
            sts_q     <= '0;
            ld_q      <= 1'b0;
            ldv_q     <= '0;
        end else begin
            acc_q     <= acc_d;
            mode_q    <= mode_d;
            bcd_q     <= bcd_d;
            wseq_q    <= wseq_d;
            rseq_q    <= rseq_d;
            wlo_q     <= wlo_d;
            clat_q    <= clat_d;
            cval_q    <= cval_d;
            sts_vld_q <= sts_vld_d;
            sts_q     <= sts_d;
            ld_q      <= ld_d;
            ldv_q     <= ldv_d;
        end
    end

    // output process
    always_comb begin
        if (sts_vld_q) begin
            rd_byte = sts_q;
        end else begin
            unique case (clat_q)
                CL_BYTE_LO, CL_WORD_LO: rd_byte = cval_q[BYTE_W-1:0];
                CL_BYTE_HI, CL_WORD_HI: rd_byte = cval_q[CNT_W-1:BYTE_W];
                default: begin
                    if (acc_q == ACC_HI || (acc_q == ACC_WORD && rseq_q == SEQ_HI)) begin
                        rd_byte = live_cnt[CNT_W-1:BYTE_W];
                    end else begin
                        rd_byte = live_cnt[BYTE_W-1:0];
                    end
                end
            endcase
        end
    end

    assign load_stb = ld_q;
    assign load_val = ldv_q;
    assign mode     = mode_q;
    assign bcd      = bcd_q;

    // A load strobe only follows a data write (R3)
    assert_load_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(wr_hit));

    // A counter-latch command leaves configuration untouched (R2)
    assert_latch_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.latch_cnt |=> ($stable(mode_q) && $stable(acc_q) && $stable(bcd_q)));

    // A held count is not replaced while no read consumes it (R8)
    assert_count_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clat_q != CL_EMPTY && !rd_hit) |=> $stable(cval_q));

    // A held status is not replaced while no read consumes it (R8)
    assert_status_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vld_q && !rd_hit) |=> ($stable(sts_q) && sts_vld_q));

    // Word-mode latch needs a second read before release (R9)
    assert_word_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clat_q == CL_WORD_LO && rd_hit && !sts_vld_q) |=> (clat_q == CL_WORD_HI));

    // A status read clears status and leaves the count latch alone (R12)
    assert_status_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vld_q && rd_hit) |=> (!sts_vld_q && $stable(clat_q)));

endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
    import tmr_host_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_CH-1:0]          load_stb,
    output logic [NUM_CH*CNT_W-1:0]    load_val,
    output logic [NUM_CH*MODE_W-1:0]   chan_mode,
    output logic [NUM_CH-1:0]          chan_bcd,
    input  logic [NUM_CH*CNT_W-1:0]    live_cnt,
    input  logic [NUM_CH-1:0]          out_lvl
);

    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    chan_cmd_t [NUM_CH-1:0] cmd;
    logic [BYTE_W-1:0]      rd_byte [NUM_CH];
    logic                   wr_ctl;
    logic                   rd_any;
    logic [BYTE_W-1:0]      rsel;
    logic [BYTE_W-1:0]      rdata_q;

    assign wr_ctl = wr_en && (addr == CTL_ADDR);
    assign rd_any = rd_en && !wr_en;

    tmr_ctl_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (wr_ctl),
        .wdata  (wdata),
        .cmd    (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_chan_port u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd[c]),
            .wr_hit   (wr_en && addr == ADDR_W'(c)),
            .rd_hit   (rd_any && addr == ADDR_W'(c)),
            .wdata    (wdata),
            .live_cnt (live_cnt[c*CNT_W +: CNT_W]),
            .out_lvl  (out_lvl[c]),
            .rd_byte  (rd_byte[c]),
            .load_stb (load_stb[c]),
            .load_val (load_val[c*CNT_W +: CNT_W]),
            .mode     (chan_mode[c*MODE_W +: MODE_W]),
            .bcd      (chan_bcd[c])
        );
    end

    always_comb begin
        rsel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c)) rsel = rd_byte[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            rdata_q <= rsel;
        end
    end

    assign rdata = rdata_q;

    // Control-port reads return zero (R13)
    assert_ctl_read_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && addr == CTL_ADDR) |=> (rdata == '0));

    // At most one channel loads per cycle (R3)
    assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

endmodule

// File: tb/tb_tmr_host_port.sv
module tb_tmr_host_port;
    import tmr_host_pkg::*;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] load_stb;
    logic [47:0] load_val;
    logic [8:0] chan_mode;
    logic [2:0] chan_bcd;
    logic [47:0] live_cnt = '0;
    logic [2:0] out_lvl = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit rd_prev = 0;

    logic [7:0]  exp_rd_q[$];
    string       rd_req_q[$];
    logic [17:0] exp_ld_q[$];
    string       ld_req_q[$];

    always #(CLK_P/2) clk = ~clk;

    tmr_host_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .load_stb(load_stb), .load_val(load_val),
        .chan_mode(chan_mode), .chan_bcd(chan_bcd), .live_cnt(live_cnt), .out_lvl(out_lvl)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares results at the falling edge where they are due
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_prev) begin
                if (exp_rd_q.size() == 0) check(32'(rdata), 32'hDEAD, "unexpected read");
                else check(32'(rdata), 32'(exp_rd_q.pop_front()), rd_req_q.pop_front());
            end
            for (int c = 0; c < 3; c++) begin
                if (load_stb[c]) begin
                    if (exp_ld_q.size() == 0) check({14'd0, 2'(c), load_val[c*16 +: 16]}, 32'hDEAD, "unexpected load");
                    else check({14'd0, 2'(c), load_val[c*16 +: 16]}, 32'(exp_ld_q.pop_front()), ld_req_q.pop_front());
                end
            end
        end
        rd_prev = rd_en && !wr_en;
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
        exp_rd_q.push_back(exp);
        rd_req_q.push_back(req);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic expect_load(input int ch, input logic [15:0] v, input string req);
        exp_ld_q.push_back({2'(ch), v});
        ld_req_q.push_back(req);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        check(32'(chan_mode), 32'h0, "R14 mode");
        check(32'(chan_bcd), 32'h0, "R14 bcd");
        check(32'(load_stb), 32'h0, "R14 strobe");
        check(32'(rdata), 32'h0, "R14 rdata");
        // R14 reset access is word: two writes to ch0 load a word
        expect_load(0, 16'hBEAD, "R14 reset word access");
        bus_write(2'd0, 8'hAD);
        bus_write(2'd0, 8'hBE);

        // R1 program ch0 word mode 2, ch1 lsb mode 5 bcd
        bus_write(2'd3, 8'h34);
        check(32'(chan_mode[2:0]), 32'd2, "R1 ch0 mode");
        bus_write(2'd3, 8'h5B);
        check(32'(chan_mode[5:3]), 32'd5, "R1 ch1 mode");
        check(32'(chan_bcd[1]), 32'd1, "R1 ch1 bcd");
        // R4 ch2 msb only mode 3
        bus_write(2'd3, 8'hA6);
        check(32'(chan_mode[8:6]), 32'd3, "R1 ch2 mode");

        // R5 word write
        expect_load(0, 16'h1234, "R5 word load");
        bus_write(2'd0, 8'h34);
        bus_write(2'd0, 8'h12);
        // R3 lsb only
        expect_load(1, 16'h00A5, "R3 lsb load");
        bus_write(2'd1, 8'hA5);
        // R4 msb only
        expect_load(2, 16'h7E00, "R4 msb load");
        bus_write(2'd2, 8'h7E);

        // R6 live reads
        live_cnt[15:0]  = 16'hBEEF;
        live_cnt[31:16] = 16'h2468;
        live_cnt[47:32] = 16'h1357;
        bus_read(2'd0, 8'hEF, "R6 word lo");
        bus_read(2'd0, 8'hBE, "R6 word hi");
        bus_read(2'd0, 8'hEF, "R6 word lo again");
        bus_read(2'd2, 8'h13, "R6 msb only");
        bus_read(2'd2, 8'h13, "R6 msb only repeat");
        bus_read(2'd1, 8'h68, "R6 lsb only");

        // R7/R8 counter latch on ch0, R2 keeps config
        bus_write(2'd3, 8'h00);
        check(32'(chan_mode[2:0]), 32'd2, "R2 mode kept");
        check(32'(chan_bcd[0]), 32'd0, "R2 bcd kept");
        live_cnt[15:0] = 16'h1122;
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, 8'hEF, "R7 latched lo");
        bus_read(2'd0, 8'hBE, "R8 latch not replaced");
        // R9 released after two reads; live sequencer was at high byte
        bus_read(2'd0, 8'h11, "R9 live after word latch");
        bus_read(2'd0, 8'h22, "R9 live sequencer resumes");

        // R9 byte-mode latch on ch1
        bus_write(2'd3, 8'h40);
        live_cnt[31:16] = 16'h9999;
        bus_read(2'd1, 8'h68, "R9 byte latch");
        bus_read(2'd1, 8'h99, "R9 byte latch released");

        // R10/R11/R12 read-back count+status on ch0 and ch2
        out_lvl = 3'b101;
        bus_write(2'd3, 8'hCA);
        live_cnt[15:0]  = 16'h5555;
        live_cnt[47:32] = 16'hABCD;
        bus_read(2'd0, 8'hB4, "R11 status ch0");
        bus_read(2'd0, 8'h22, "R12 count after status lo");
        bus_read(2'd0, 8'h11, "R12 count after status hi");
        bus_read(2'd2, 8'hA6, "R11 status ch2");
        bus_read(2'd2, 8'h13, "R10 count ch2");
        bus_read(2'd2, 8'hAB, "R10 ch2 live after");
        bus_read(2'd1, 8'h99, "R10 ch1 unselected");

        // R8 status latch once, R10 status only
        bus_write(2'd3, 8'hE4);
        out_lvl = 3'b111;
        bus_write(2'd3, 8'hE4);
        bus_read(2'd1, 8'h1B, "R8 status kept");
        bus_read(2'd1, 8'h99, "R12 status cleared");

        // R13 control read
        bus_read(2'd3, 8'h00, "R13 ctl read");

        // R1 reprogram resets write sequencer
        bus_write(2'd0, 8'h55);
        bus_write(2'd3, 8'h30);
        check(32'(chan_mode[2:0]), 32'd0, "R1 ch0 reprogram mode");
        expect_load(0, 16'h7766, "R1 write sequencer reset");
        bus_write(2'd0, 8'h66);
        bus_write(2'd0, 8'h77);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(32'(exp_rd_q.size() + exp_ld_q.size()), 32'd0, "all expected results seen");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule